// File: doc/BRIEF.md
# Bridge Transaction Sorter and Delayed-Request Queue

This block handles one direction of a bus-to-bus bridge. It takes each request offered on the initiator side, decodes its 4-bit bus command and picks one of three handling paths. Memory writes are posted. The block accepts them at once into a first-in first-out write buffer and forwards them to the target side later. I/O writes, configuration writes and every kind of read are delayed. The first attempt of a delayed request gets a retry, and the request is recorded in a slot of the delayed table. The table issues its entries to the target side one at a time, in arrival order. When the target reports completion, the entry keeps the result. For reads, the result is the returned data.

The initiator must repeat a delayed request to collect its result. A repeat counts as the same request only when command, address and byte enables all match an entry. For delayed writes, the write data must also match. A repeat that finds a finished entry is accepted, receives the stored data, and frees the slot. A repeat that finds an unfinished entry is retried again. A repeat that matches nothing is handled as a new request. Writes are never combined, merged or collapsed: every accepted posted write becomes exactly one target transaction with its own byte enables and data.

The response (accept or retry) is combinational in the cycle the request is offered. The target port uses a valid/ready handshake. Completion of the delayed transaction in flight is a one-cycle pulse with read data.

Top module: `bridge_xact_queue`

## Requirements
- R1: `rsp_kind` reports the class of the offered command. Codes 0111 and 1111 give 1 (posted). Codes 0011 and 1011 give 2 (delayed write). Codes 0010, 0110, 1010, 1100 and 1110 give 3 (delayed read). Every other code gives 0 (unsupported).
- R2: A posted write is accepted in the cycle it is offered when the write buffer has room. Accepted posted writes reach the target port with `tgt_posted`=1, in acceptance order, with unchanged command, address, byte enables and data.
- R3: A posted write offered while the write buffer holds `PQ_DEPTH` entries is retried and never reaches the target.
- R4: A delayed request that matches no table entry is retried. If a slot is free, the request is stored. Stored requests are issued with `tgt_posted`=0 in the order they were stored, and only one is outstanding until `tgt_cpl` pulses.
- R5: A repeat that matches an entry whose completion has not arrived is retried.
- R6: A repeat that matches a completed entry is accepted. For a read, it returns the completion data in `rsp_rdata`; for a write, it returns zero. The slot is then freed, so the next identical request is treated as new and retried.
- R7: A request that differs from every entry in command, address or byte enables, or in write data for a delayed write, is stored as a separate entry. No two entries are ever identical.
- R8: A new delayed request offered while all `DQ_DEPTH` slots are in use is retried and never issued.
- R9: Several posted writes to the same DWORD produce the same number of separate target transactions, each with its own byte enables and data.
- R10: When a delayed request is not currently offered on the target port, a waiting posted write is issued first, ahead of older delayed entries. While `tgt_valid` is high and `tgt_ready` low, every target-side output stays unchanged.
- R11: An unsupported command gets neither accept nor retry and causes no target transaction.
- R12: `rsp_accept` and `rsp_retry` are never high together, and both are low when no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Initiator request offered this cycle |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | 32 | Request address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_accept | output | 1 | Request completed this cycle |
| rsp_retry | output | 1 | Request answered with retry |
| rsp_kind | output | 2 | Class of the offered command |
| rsp_rdata | output | 32 | Data returned on accepted delayed repeat |
| tgt_valid | output | 1 | Target transaction offered |
| tgt_ready | input | 1 | Target takes the offered transaction |
| tgt_posted | output | 1 | Offered transaction is a posted write |
| tgt_cmd | output | 4 | Command of offered transaction |
| tgt_addr | output | 32 | Address of offered transaction |
| tgt_be | output | 4 | Byte enables of offered transaction |
| tgt_wdata | output | 32 | Write data of offered transaction |
| tgt_cpl | input | 1 | Outstanding delayed transaction finished |
| tgt_rdata | input | 32 | Read data returned with completion |

## Verification
The sorting is tried with all sixteen command codes. This separates posted, delayed-write, delayed-read and ignored codes by their response and by what appears at the target port. Directed sequences cover the following:
- An identical repeat before and after completion, which tells a pending entry from a finished one.
- Repeats that differ only in write data or in byte enables, which show that they are kept as new entries.
- Bursts that fill the write buffer or the delayed table, which show the retry on overflow.
- A mix of posted and delayed requests behind a stalled target, which exposes both the posted priority and the hold of an offered delayed transaction.

A seeded random mix of posted writes and repeated reads under a randomly stalling target checks write order and returned read data.

// File: rtl/bxq_pkg.sv
`timescale 1ns/1ps
package bxq_pkg;
    localparam int XQ_AW  = 32;
    localparam int XQ_DW  = 32;
    localparam int XQ_BEW = XQ_DW / 8;

    typedef enum logic [3:0] {
        CMD_IORD   = 4'h2,
        CMD_IOWR   = 4'h3,
        CMD_MRD    = 4'h6,
        CMD_MWR    = 4'h7,
        CMD_CFGRD  = 4'hA,
        CMD_CFGWR  = 4'hB,
        CMD_MRDMUL = 4'hC,
        CMD_MRDLN  = 4'hE,
        CMD_MWRINV = 4'hF
    } cmd_e;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_POSTED = 2'd1,
        K_DWR    = 2'd2,
        K_DRD    = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        SL_FREE, SL_WAIT, SL_ISSUED, SL_DONE
    } slot_e;

    typedef struct packed {
        logic [3:0]        cmd;
        logic [XQ_AW-1:0]  addr;
        logic [XQ_BEW-1:0] be;
        logic [XQ_DW-1:0]  data;
    } xact_t;

    function automatic kind_e classify(input logic [3:0] c);
        kind_e k;
        case (c)
            CMD_MWR, CMD_MWRINV:                               k = K_POSTED;
            CMD_IOWR, CMD_CFGWR:                               k = K_DWR;
            CMD_IORD, CMD_MRD, CMD_CFGRD, CMD_MRDMUL, CMD_MRDLN: k = K_DRD;
            default:                                           k = K_NONE;
        endcase
        return k;
    endfunction

    // Repeat identity: write data only counts for delayed writes.
    function automatic logic same_req(input xact_t a, input xact_t b);
        logic base;
        base = (a.cmd == b.cmd) && (a.addr == b.addr) && (a.be == b.be);
        if (classify(a.cmd) == K_DWR)
            return base && (a.data == b.data);
        return base;
    endfunction
endpackage

// File: rtl/bxq_fifo.sv
`timescale 1ns/1ps
module bxq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/bxq_delay_table.sv
`timescale 1ns/1ps
module bxq_delay_table
    import bxq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  xact_t            lk_req,
    output logic             lk_accept,
    output logic             lk_retry,
    output logic [XQ_DW-1:0] lk_rdata,
    output logic [DEPTH-1:0] lk_hit,
    output logic             iss_valid,
    input  logic             iss_ready,
    output xact_t            iss_req,
    input  logic             cpl_valid,
    input  logic [XQ_DW-1:0] cpl_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    slot_e            st [DEPTH];
    xact_t            rq [DEPTH];
    logic [XQ_DW-1:0] rd [DEPTH];

    logic          any_hit, hit_done, has_free;
    logic [IW-1:0] hit_idx, free_idx, ord_head, cur_idx;
    logic          ord_empty, ord_full, inflight;
    logic          do_alloc, do_free, do_iss;

    always_comb begin
        hit_idx  = '0;
        hit_done = 1'b0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            lk_hit[i] = (st[i] != SL_FREE) && same_req(rq[i], lk_req);
            if (lk_hit[i]) begin
                hit_idx  = IW'(i);
                hit_done = (st[i] == SL_DONE);
            end
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (st[i] == SL_FREE) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    assign any_hit   = |lk_hit;
    assign do_alloc  = lk_valid && !any_hit && has_free && !ord_full;
    assign do_free   = lk_valid && any_hit && hit_done;
    assign lk_accept = do_free;
    assign lk_retry  = lk_valid && !do_free;
    assign lk_rdata  = do_free ? rd[hit_idx] : '0;

    assign iss_valid = !inflight && !ord_empty;
    assign iss_req   = rq[ord_head];
    assign do_iss    = iss_valid && iss_ready;

    // Slot indices in store order: issue follows arrival.
    bxq_fifo #(.W(IW), .DEPTH(DEPTH)) u_order (
        .clk   (clk),
        .rst   (rst),
        .push  (do_alloc),
        .din   (free_idx),
        .pop   (do_iss),
        .dout  (ord_head),
        .empty (ord_empty),
        .full  (ord_full)
    );

    always_ff @(posedge clk) begin
        if (do_alloc) rq[free_idx] <= lk_req;
        if (cpl_valid && inflight)
            rd[cur_idx] <= (classify(rq[cur_idx].cmd) == K_DRD) ? cpl_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) st[i] <= SL_FREE;
            inflight <= 1'b0;
            cur_idx  <= '0;
        end else begin
            if (do_alloc) st[free_idx] <= SL_WAIT;
            if (do_iss) begin
                st[ord_head] <= SL_ISSUED;
                inflight     <= 1'b1;
                cur_idx      <= ord_head;
            end
            if (cpl_valid && inflight) begin
                st[cur_idx] <= SL_DONE;
                inflight    <= 1'b0;
            end
            if (do_free) st[hit_idx] <= SL_FREE;
        end
    end
endmodule

// File: rtl/bridge_xact_queue.sv
`timescale 1ns/1ps
module bridge_xact_queue
    import bxq_pkg::*;
#(
    parameter int PQ_DEPTH = 4,
    parameter int DQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_cmd,
    input  logic [XQ_AW-1:0]  req_addr,
    input  logic [XQ_BEW-1:0] req_be,
    input  logic [XQ_DW-1:0]  req_wdata,
    output logic              rsp_accept,
    output logic              rsp_retry,
    output logic [1:0]        rsp_kind,
    output logic [XQ_DW-1:0]  rsp_rdata,
    output logic              tgt_valid,
    input  logic              tgt_ready,
    output logic              tgt_posted,
    output logic [3:0]        tgt_cmd,
    output logic [XQ_AW-1:0]  tgt_addr,
    output logic [XQ_BEW-1:0] tgt_be,
    output logic [XQ_DW-1:0]  tgt_wdata,
    input  logic              tgt_cpl,
    input  logic [XQ_DW-1:0]  tgt_rdata
);
    localparam int XW = $bits(xact_t);

    kind_e         kind;
    xact_t         req, pw_head, dq_head, out_x;
    logic          pw_valid, pw_full, pw_empty, pw_pop;
    logic          dq_valid, dq_accept, dq_retry, dq_iss_valid, dq_iss_ready;
    logic [XQ_DW-1:0] dq_rdata;
    logic [DQ_DEPTH-1:0] dq_hit;
    logic          sel_post, sel_dly, hold_dly;

    assign kind     = classify(req_cmd);
    assign req      = '{cmd: req_cmd, addr: req_addr, be: req_be, data: req_wdata};
    assign pw_valid = req_valid && (kind == K_POSTED);
    assign dq_valid = req_valid && ((kind == K_DWR) || (kind == K_DRD));

    bxq_fifo #(.W(XW), .DEPTH(PQ_DEPTH)) u_post (
        .clk   (clk),
        .rst   (rst),
        .push  (pw_valid && !pw_full),
        .din   (req),
        .pop   (pw_pop),
        .dout  (pw_head),
        .empty (pw_empty),
        .full  (pw_full)
    );

    bxq_delay_table #(.DEPTH(DQ_DEPTH)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (dq_valid),
        .lk_req    (req),
        .lk_accept (dq_accept),
        .lk_retry  (dq_retry),
        .lk_rdata  (dq_rdata),
        .lk_hit    (dq_hit),
        .iss_valid (dq_iss_valid),
        .iss_ready (dq_iss_ready),
        .iss_req   (dq_head),
        .cpl_valid (tgt_cpl),
        .cpl_data  (tgt_rdata)
    );

    // Posted writes go first unless a delayed one is already on offer.
    assign sel_post     = !pw_empty && !hold_dly;
    assign sel_dly      = !sel_post && dq_iss_valid;
    assign pw_pop       = sel_post && tgt_ready;
    assign dq_iss_ready = sel_dly && tgt_ready;
    assign out_x        = sel_post ? pw_head : dq_head;

    always_ff @(posedge clk) begin
        if (rst) hold_dly <= 1'b0;
        else     hold_dly <= sel_dly && !tgt_ready;
    end

    assign tgt_valid  = sel_post || sel_dly;
    assign tgt_posted = sel_post;
    assign tgt_cmd    = out_x.cmd;
    assign tgt_addr   = out_x.addr;
    assign tgt_be     = out_x.be;
    assign tgt_wdata  = out_x.data;

    assign rsp_accept = (pw_valid && !pw_full) || dq_accept;
    assign rsp_retry  = (pw_valid && pw_full) || dq_retry;
    assign rsp_kind   = req_valid ? kind : K_NONE;
    assign rsp_rdata  = dq_rdata;
endmodule

// File: rtl/bxq_checker.sv
`timescale 1ns/1ps
module bxq_checker
    import bxq_pkg::*;
#(
    parameter int DQ_DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rsp_accept,
    input logic              rsp_retry,
    input logic [1:0]        rsp_kind,
    input logic              tgt_valid,
    input logic              tgt_ready,
    input logic              tgt_posted,
    input logic [3:0]        tgt_cmd,
    input logic [XQ_AW-1:0]  tgt_addr,
    input logic [XQ_BEW-1:0] tgt_be,
    input logic [XQ_DW-1:0]  tgt_wdata,
    input logic [DQ_DEPTH-1:0] dq_hit
);
    // R12
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_accept && rsp_retry));

    // R11
    none_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_kind == K_NONE) |-> (!rsp_accept && !rsp_retry));

    // R10
    tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && !tgt_ready) |=> (tgt_valid && $stable(tgt_posted) &&
        $stable(tgt_cmd) && $stable(tgt_addr) && $stable(tgt_be) && $stable(tgt_wdata)));

    // R2
    post_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_accept && rsp_kind == K_POSTED) |=> tgt_valid);

    // R7
    no_dup_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dq_hit));
endmodule

bind bridge_xact_queue bxq_checker #(.DQ_DEPTH(DQ_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rsp_accept (rsp_accept),
    .rsp_retry  (rsp_retry),
    .rsp_kind   (rsp_kind),
    .tgt_valid  (tgt_valid),
    .tgt_ready  (tgt_ready),
    .tgt_posted (tgt_posted),
    .tgt_cmd    (tgt_cmd),
    .tgt_addr   (tgt_addr),
    .tgt_be     (tgt_be),
    .tgt_wdata  (tgt_wdata),
    .dq_hit     (dq_hit)
);

// File: tb/test_bridge_xact_queue.sv
`timescale 1ns/1ps
module test_bridge_xact_queue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_accept, rsp_retry;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_rdata;
    logic        tgt_valid, tgt_posted;
    logic        tgt_ready = 1'b0;
    logic [3:0]  tgt_cmd;
    logic [31:0] tgt_addr, tgt_wdata;
    logic [3:0]  tgt_be;
    logic        tgt_cpl = 1'b0;
    logic [31:0] tgt_rdata = '0;

    int total = 0;
    int bad = 0;
    int rdy_mode = 0;
    int lg_n = 0;
    logic [3:0]  lg_cmd  [512];
    logic [31:0] lg_addr [512];
    logic [3:0]  lg_be   [512];
    logic [31:0] lg_data [512];
    logic        lg_post [512];

    always #5 clk = ~clk;

    bridge_xact_queue i_bridge_xact_queue (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_accept(rsp_accept), .rsp_retry(rsp_retry), .rsp_kind(rsp_kind),
        .rsp_rdata(rsp_rdata), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
        .tgt_posted(tgt_posted), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr),
        .tgt_be(tgt_be), .tgt_wdata(tgt_wdata), .tgt_cpl(tgt_cpl),
        .tgt_rdata(tgt_rdata)
    );

    function automatic logic [31:0] rd_val(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic int exp_kind(input logic [3:0] c);
        case (c)
            4'h7, 4'hF:                         return 1;
            4'h3, 4'hB:                         return 2;
            4'h2, 4'h6, 4'hA, 4'hC, 4'hE:        return 3;
            default:                            return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Target model: logs handshakes, completes delayed ones 3 cycles later.
    initial begin
        int cpl_cnt;
        logic [31:0] cpl_val;
        cpl_cnt = 0;
        cpl_val = '0;
        forever begin
            @(negedge clk);
            tgt_cpl = 1'b0;
            if (cpl_cnt > 0) begin
                cpl_cnt--;
                if (cpl_cnt == 0) begin
                    tgt_cpl   = 1'b1;
                    tgt_rdata = cpl_val;
                end
            end
            tgt_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'($urandom % 2) : 1'b0;
            #2;
            if (!rst && tgt_valid && tgt_ready && lg_n < 512) begin
                lg_cmd[lg_n]  = tgt_cmd;
                lg_addr[lg_n] = tgt_addr;
                lg_be[lg_n]   = tgt_be;
                lg_data[lg_n] = tgt_wdata;
                lg_post[lg_n] = tgt_posted;
                lg_n++;
                if (!tgt_posted) begin
                    cpl_cnt = 3;
                    cpl_val = rd_val(tgt_addr);
                end
            end
        end
    end

    task automatic send(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                        input logic [31:0] d, output logic acc, output logic ret,
                        output logic [1:0] k, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = c;
        req_addr  = a;
        req_be    = b;
        req_wdata = d;
        #1;
        acc = rsp_accept;
        ret = rsp_retry;
        k   = rsp_kind;
        rd  = rsp_rdata;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic complete(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                            input logic [31:0] d, input logic [31:0] exp, input string tag);
        logic acc, ret;
        logic [1:0] k;
        logic [31:0] rd;
        acc = 1'b0;
        for (int t = 0; t < 60 && !acc; t++) begin
            send(c, a, b, d, acc, ret, k, rd);
            if (!acc) wait_cyc(1);
        end
        chk(acc, {tag, " repeat accepted"}, 32'(acc), 32'd1);
        chk(rd == exp, {tag, " completion data"}, rd, exp);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic acc, ret;
        logic [1:0] k;
        logic [31:0] rd;
        int np, nlog;
        logic [31:0] ex_addr [128];
        logic [3:0]  ex_be   [128];
        logic [31:0] ex_data [128];
        logic [3:0]  ex_cmd  [128];

        void'($urandom(32'd2718));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #3;
        // R12 reset state
        chk(!tgt_valid, "R12 reset tgt_valid", 32'(tgt_valid), 32'd0);
        chk(!rsp_accept && !rsp_retry, "R12 idle response", {30'd0, rsp_accept, rsp_retry}, 32'd0);

        // R1 / R11: every command code
        rdy_mode = 1;
        lg_n = 0;
        for (int c = 0; c < 16; c++) begin
            logic [31:0] a;
            a = 32'h100 + 32'(c) * 16;
            send(4'(c), a, 4'hF, 32'hC0DE_0000 + 32'(c), acc, ret, k, rd);
            chk(int'(k) == exp_kind(4'(c)), "R1 class code", 32'(k), 32'(exp_kind(4'(c))));
            chk(!(acc && ret), "R12 exclusive", {30'd0, acc, ret}, 32'd0);
            case (exp_kind(4'(c)))
                0: chk(!acc && !ret, "R11 ignored code", {30'd0, acc, ret}, 32'd0);
                1: chk(acc, "R2 posted accepted", 32'(acc), 32'd1);
                default: begin
                    chk(ret, "R4 first attempt retried", 32'(ret), 32'd1);
                    complete(4'(c), a, 4'hF, 32'hC0DE_0000 + 32'(c),
                             exp_kind(4'(c)) == 3 ? rd_val(a) : 32'd0, "R6");
                end
            endcase
        end
        wait_cyc(6);
        chk(lg_n == 9, "R11 target count", 32'(lg_n), 32'd9);

        // R4 / R5 / R6: pending then done
        rdy_mode = 0;
        wait_cyc(2);
        lg_n = 0;
        send(4'h6, 32'h1000, 4'hF, 0, acc, ret, k, rd);
        chk(ret, "R4 new read retried", 32'(ret), 32'd1);
        @(negedge clk); #3;
        chk(tgt_valid && !tgt_posted && tgt_addr == 32'h1000, "R4 issued delayed", tgt_addr, 32'h1000);
        send(4'h6, 32'h1000, 4'hF, 0, acc, ret, k, rd);
        chk(ret && !acc, "R5 pending repeat retried", 32'(ret), 32'd1);
        rdy_mode = 1;
        wait_cyc(10);
        send(4'h6, 32'h1000, 4'hF, 0, acc, ret, k, rd);
        chk(acc, "R6 done repeat accepted", 32'(acc), 32'd1);
        chk(rd == rd_val(32'h1000), "R6 read data", rd, rd_val(32'h1000));
        send(4'h6, 32'h1000, 4'hF, 0, acc, ret, k, rd);
        chk(ret, "R6 freed slot treated new", 32'(ret), 32'd1);
        complete(4'h6, 32'h1000, 4'hF, 0, rd_val(32'h1000), "R6");

        // R7: mismatched repeats become new entries
        rdy_mode = 0;
        wait_cyc(4);
        lg_n = 0;
        send(4'h3, 32'h1800, 4'hF, 32'hAAAA_0001, acc, ret, k, rd);
        send(4'h3, 32'h1800, 4'hF, 32'hAAAA_0002, acc, ret, k, rd);
        chk(ret, "R7 data mismatch retried", 32'(ret), 32'd1);
        send(4'h2, 32'h1800, 4'hF, 0, acc, ret, k, rd);
        send(4'h2, 32'h1800, 4'h3, 0, acc, ret, k, rd);
        chk(ret, "R7 be mismatch retried", 32'(ret), 32'd1);
        rdy_mode = 1;
        wait_cyc(30);
        chk(lg_n == 4, "R7 separate entries issued", 32'(lg_n), 32'd4);
        chk(lg_data[0] == 32'hAAAA_0001 && lg_data[1] == 32'hAAAA_0002, "R4 fifo order data", lg_data[1], 32'hAAAA_0002);
        chk(lg_be[2] == 4'hF && lg_be[3] == 4'h3, "R4 fifo order be", 32'(lg_be[3]), 32'h3);
        complete(4'h3, 32'h1800, 4'hF, 32'hAAAA_0001, 0, "R7");
        complete(4'h3, 32'h1800, 4'hF, 32'hAAAA_0002, 0, "R7");
        complete(4'h2, 32'h1800, 4'hF, 0, rd_val(32'h1800), "R7");
        complete(4'h2, 32'h1800, 4'h3, 0, rd_val(32'h1800), "R7");

        // R8: delayed table full
        rdy_mode = 0;
        wait_cyc(4);
        lg_n = 0;
        for (int i = 0; i < 4; i++) send(4'h6, 32'h2000 + 32'(i) * 4, 4'hF, 0, acc, ret, k, rd);
        send(4'h6, 32'h3000, 4'hF, 0, acc, ret, k, rd);
        chk(ret, "R8 full table retried", 32'(ret), 32'd1);
        rdy_mode = 1;
        wait_cyc(30);
        chk(lg_n == 4, "R8 overflow not issued", 32'(lg_n), 32'd4);
        for (int i = 0; i < 4; i++)
            complete(4'h6, 32'h2000 + 32'(i) * 4, 4'hF, 0, rd_val(32'h2000 + 32'(i) * 4), "R8");
        complete(4'h6, 32'h3000, 4'hF, 0, rd_val(32'h3000), "R8");

        // R3: posted buffer full
        rdy_mode = 0;
        wait_cyc(4);
        lg_n = 0;
        for (int i = 0; i < 4; i++) begin
            send(4'h7, 32'h4000 + 32'(i) * 4, 4'hF, 32'(i), acc, ret, k, rd);
            chk(acc, "R2 posted accepted", 32'(acc), 32'd1);
        end
        send(4'h7, 32'h4100, 4'hF, 32'h99, acc, ret, k, rd);
        chk(ret && !acc, "R3 full buffer retried", 32'(ret), 32'd1);
        rdy_mode = 1;
        wait_cyc(10);
        chk(lg_n == 4, "R3 overflow dropped", 32'(lg_n), 32'd4);
        chk(lg_addr[3] == 32'h400C && lg_post[3], "R2 posted order", lg_addr[3], 32'h400C);

        // R9: same DWORD writes stay separate
        lg_n = 0;
        send(4'h7, 32'h5000, 4'h1, 32'h11, acc, ret, k, rd);
        send(4'h7, 32'h5000, 4'h2, 32'h2200, acc, ret, k, rd);
        send(4'hF, 32'h5000, 4'h1, 32'h33, acc, ret, k, rd);
        wait_cyc(8);
        chk(lg_n == 3, "R9 three target writes", 32'(lg_n), 32'd3);
        chk(lg_be[0] == 4'h1 && lg_data[0] == 32'h11, "R9 first write", lg_data[0], 32'h11);
        chk(lg_be[1] == 4'h2 && lg_data[1] == 32'h2200, "R9 second write", lg_data[1], 32'h2200);
        chk(lg_cmd[2] == 4'hF && lg_data[2] == 32'h33, "R9 third write", lg_data[2], 32'h33);

        // R10: posted passes queued delayed
        rdy_mode = 0;
        wait_cyc(2);
        lg_n = 0;
        send(4'h7, 32'h6000, 4'hF, 1, acc, ret, k, rd);
        send(4'h6, 32'h6100, 4'hF, 0, acc, ret, k, rd);
        send(4'h7, 32'h6004, 4'hF, 2, acc, ret, k, rd);
        rdy_mode = 1;
        wait_cyc(12);
        chk(lg_n == 3 && lg_addr[1] == 32'h6004 && lg_addr[2] == 32'h6100, "R10 posted priority", lg_addr[1], 32'h6004);
        complete(4'h6, 32'h6100, 4'hF, 0, rd_val(32'h6100), "R10");

        // R10: offered delayed is held
        rdy_mode = 0;
        wait_cyc(2);
        lg_n = 0;
        send(4'hA, 32'h6200, 4'hF, 0, acc, ret, k, rd);
        send(4'h7, 32'h6300, 4'hF, 3, acc, ret, k, rd);
        @(negedge clk); #3;
        chk(tgt_valid && !tgt_posted && tgt_addr == 32'h6200, "R10 hold delayed", tgt_addr, 32'h6200);
        rdy_mode = 1;
        wait_cyc(12);
        chk(lg_n == 2 && lg_addr[0] == 32'h6200 && lg_addr[1] == 32'h6300, "R10 held order", lg_addr[0], 32'h6200);
        complete(4'hA, 32'h6200, 4'hF, 0, rd_val(32'h6200), "R10");

        // Random mix
        rdy_mode = 2;
        wait_cyc(4);
        lg_n = 0;
        np = 0;
        for (int it = 0; it < 80; it++) begin
            int r;
            logic [31:0] a;
            r = $urandom % 3;
            a = $urandom & 32'h0000_FFFC;
            if (r == 0) begin
                logic [3:0] rc;
                case ($urandom % 5)
                    0: rc = 4'h6;
                    1: rc = 4'hC;
                    2: rc = 4'hE;
                    3: rc = 4'h2;
                    default: rc = 4'hA;
                endcase
                complete(rc, a, 4'hF, 0, rd_val(a), "R6 random");
            end else if (np < 128) begin
                logic [3:0] pc, pb;
                logic [31:0] pd;
                pc = (r == 1) ? 4'h7 : 4'hF;
                pb = 4'($urandom % 15 + 1);
                pd = $urandom;
                acc = 1'b0;
                for (int t = 0; t < 60 && !acc; t++) begin
                    send(pc, a, pb, pd, acc, ret, k, rd);
                    if (!acc) wait_cyc(1);
                end
                if (acc) begin
                    ex_cmd[np] = pc; ex_addr[np] = a; ex_be[np] = pb; ex_data[np] = pd;
                    np++;
                end
            end
        end
        rdy_mode = 1;
        wait_cyc(20);
        nlog = 0;
        for (int i = 0; i < lg_n; i++) begin
            if (lg_post[i]) begin
                if (nlog < np)
                    chk(lg_cmd[i] == ex_cmd[nlog] && lg_addr[i] == ex_addr[nlog] &&
                        lg_be[i] == ex_be[nlog] && lg_data[i] == ex_data[nlog],
                        "R2 random posted order", lg_data[i], ex_data[nlog]);
                nlog++;
            end
        end
        chk(nlog == np, "R9 random posted count", 32'(nlog), 32'(np));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule